// File: doc/BRIEF.md
# Receive Packet-Available Status Generator

This block produces the "data ready to read" status for every receive port of a multi-port PHY device. For each port it watches the receive FIFO fill level in bytes and the push and pop strobes that mark end-of-packet words. From the strobes it keeps a count of the complete packets in each FIFO. A port is reported as available when that count is non-zero, or when its fill level has reached a programmable byte threshold.

The status leaves the block in two ways. One direct flag per port is driven all the time. A single polled flag reports whichever port the link layer addresses on the 5-bit poll address bus. The polled flag comes with an output-enable, so a pad driver can float the shared line when the address is the null address 5'h1F or belongs to no local port. The polled path is registered, so the link layer can scan all ports while a transfer from another port is in progress.

Top module: `pkt_avail_status`

## Requirements
- R1: A port's direct flag is high while its complete-packet count is non-zero, whatever its fill level.
- R2: With a non-zero threshold and no complete packet held, a port's direct flag is high exactly when its fill level is greater than or equal to the threshold. It is low when the fill level is below the threshold.
- R3: The threshold resets to 32 bytes. A value written with `thr_wr_en` high at a clock edge applies from that edge on.
- R4: A threshold of zero makes every direct flag high.
- R5: At each clock edge, a port's packet count goes up by one on an end-of-packet push alone, and down by one on a pop alone. It holds when both strobes come together, when neither is present, when a pop meets a count of zero, and when a push meets the maximum count.
- R6: `poll_avail` and `poll_oe` are registered. After an edge they reflect the address on `poll_addr` and the availability of that port as they stood just before that edge.
- R7: `poll_oe` is low, and `poll_avail` is low, after an edge at which the sampled address was 5'h1F or matched no local port.
- R8: Port i answers to poll address PORT_BASE + i. The default PORT_BASE is 0, so ports 0..3 use addresses 0..3.
- R9: Direct flags do not depend on the poll address. Polling one port does not disturb another port's flag or count.
- R10: After reset, all packet counts are zero and `poll_oe` and `poll_avail` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thr_wr_en | input | 1 | Threshold write strobe |
| thr_wr_data | input | FILL_W | New threshold in bytes |
| fill_level | input | NUM_PORTS*FILL_W | Per-port FIFO fill level in bytes, port 0 in the low bits |
| eop_push | input | NUM_PORTS | End-of-packet word written to the port's FIFO |
| eop_pop | input | NUM_PORTS | End-of-packet word read from the port's FIFO |
| poll_addr | input | ADDR_W | Address of the port being polled |
| direct_avail | output | NUM_PORTS | Per-port packet-available flags |
| poll_avail | output | 1 | Polled packet-available flag |
| poll_oe | output | 1 | Output enable for the polled flag |

## Verification
Each direct flag is a combinational function of the fill level and of the registered count and threshold. The bench therefore checks it one nanosecond after driving inputs at the falling edge, against a model that updates counts and threshold only at the following rising edge. The polled flag and its enable are due one rising edge after the address is presented. The driver computes that expected pair before the edge and queues it. A monitor pops the queue two nanoseconds after the rising edge and compares, so every polled result is checked exactly one cycle after its stimulus.

// File: rtl/pav_pkg.sv
package pav_pkg;
  localparam logic [4:0] NULL_PORT_ADDR = 5'h1F;

  typedef enum logic [1:0] {
    CNT_HOLD = 2'd0,
    CNT_INC  = 2'd1,
    CNT_DEC  = 2'd2
  } cnt_action_e;
endpackage

// File: rtl/pav_eop_cnt.sv
module pav_eop_cnt
  import pav_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  logic pop,
  output logic has_pkt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  cnt_action_e      act;
  logic             cnt_en;

  always_comb begin
    act = CNT_HOLD;
    if (push && !pop && cnt_q != CNT_MAX) act = CNT_INC;
    if (pop && !push && cnt_q != '0)      act = CNT_DEC;
  end

  always_comb begin
    cnt_en = (act != CNT_HOLD);
    cnt_d  = cnt_q;
    case (act)
      CNT_INC: cnt_d = cnt_q + 1'b1;
      CNT_DEC: cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign has_pkt = (cnt_q != '0);

  assert_cnt_inc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + 1'b1);
  assert_cnt_both_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> $stable(cnt_q));
  assert_cnt_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && cnt_q == '0) |=> cnt_q == '0);
endmodule

// File: rtl/pav_avail_cmp.sv
module pav_avail_cmp #(
  parameter int FILL_W = 12
) (
  input  logic [FILL_W-1:0] fill,
  input  logic [FILL_W-1:0] thr,
  input  logic              has_pkt,
  output logic              avail
);
  logic over_thr;

  always_comb begin
    over_thr = (thr == '0) || (fill >= thr);
    avail    = has_pkt || over_thr;
  end

  always_comb begin
    if (has_pkt) assert_pkt_sets_avail_R1: assert (avail);
  end
endmodule

// File: rtl/pav_poll_sel.sv
module pav_poll_sel
  import pav_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int ADDR_W    = 5,
  parameter int PORT_BASE = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [NUM_PORTS-1:0] avail,
  output logic                 poll_avail,
  output logic                 poll_oe
);
  logic [NUM_PORTS-1:0] match;
  logic hit_d, avail_d;
  logic hit_q, avail_q;

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_dec
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(PORT_BASE + i);
    assign match[i] = (addr == MY_ADDR) && (addr != ADDR_W'(NULL_PORT_ADDR));
  end

  always_comb begin
    hit_d   = |match;
    avail_d = |(match & avail);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q   <= 1'b0;
      avail_q <= 1'b0;
    end else begin
      hit_q   <= hit_d;
      avail_q <= avail_d;
    end
  end

  assign poll_oe    = hit_q;
  assign poll_avail = avail_q;

  assert_null_addr_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_W'(NULL_PORT_ADDR)) |=> !poll_oe && !poll_avail);
  assert_avail_implies_oe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    poll_avail |-> poll_oe);
  assert_poll_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_W'(PORT_BASE)) |=> poll_oe && (poll_avail == $past(avail[0])));
endmodule

// File: rtl/pkt_avail_status.sv
module pkt_avail_status #(
  parameter int NUM_PORTS = 4,
  parameter int FILL_W    = 12,
  parameter int CNT_W     = 6,
  parameter int ADDR_W    = 5,
  parameter int PORT_BASE = 0,
  parameter int THR_RESET = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        thr_wr_en,
  input  logic [FILL_W-1:0]           thr_wr_data,
  input  logic [NUM_PORTS*FILL_W-1:0] fill_level,
  input  logic [NUM_PORTS-1:0]        eop_push,
  input  logic [NUM_PORTS-1:0]        eop_pop,
  input  logic [ADDR_W-1:0]           poll_addr,
  output logic [NUM_PORTS-1:0]        direct_avail,
  output logic                        poll_avail,
  output logic                        poll_oe
);
  localparam logic [FILL_W-1:0] THR_DEF = FILL_W'(THR_RESET);

  logic [1:0]           rst_sync_q;
  logic                 rst_n_i;
  logic [FILL_W-1:0]    thr_q, thr_d;
  logic [NUM_PORTS-1:0] has_pkt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  always_comb thr_d = thr_wr_data;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i)       thr_q <= THR_DEF;
    else if (thr_wr_en) thr_q <= thr_d;
  end

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
    pav_eop_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n_i),
      .push    (eop_push[i]),
      .pop     (eop_pop[i]),
      .has_pkt (has_pkt[i])
    );
    pav_avail_cmp #(.FILL_W(FILL_W)) u_cmp (
      .fill    (fill_level[i*FILL_W +: FILL_W]),
      .thr     (thr_q),
      .has_pkt (has_pkt[i]),
      .avail   (direct_avail[i])
    );
  end

  pav_poll_sel #(
    .NUM_PORTS (NUM_PORTS),
    .ADDR_W    (ADDR_W),
    .PORT_BASE (PORT_BASE)
  ) u_poll (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .addr       (poll_addr),
    .avail      (direct_avail),
    .poll_avail (poll_avail),
    .poll_oe    (poll_oe)
  );

  assert_thr_write_R3: assert property (@(posedge clk) disable iff (!rst_n_i)
    thr_wr_en |=> thr_q == $past(thr_wr_data));
  assert_zero_thr_all_R4: assert property (@(posedge clk) disable iff (!rst_n_i)
    (thr_q == '0) |-> &direct_avail);
endmodule

// File: tb/pkt_avail_status_test.sv
module pkt_avail_status_test;
  localparam int NP = 4;
  localparam int FW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic thr_wr_en = 1'b0;
  logic [FW-1:0] thr_wr_data = '0;
  logic [NP*FW-1:0] fill_level;
  logic [NP-1:0] eop_push = '0, eop_pop = '0;
  logic [4:0] poll_addr = 5'h1F;
  logic [NP-1:0] direct_avail;
  logic poll_avail, poll_oe;

  int fill_m [NP];
  int cnt_m [NP];
  int thr_m;
  int total = 0, bad = 0;
  bit done = 0;
  logic [1:0] expq [$];
  string tagq [$];

  always #10 clk = ~clk;

  always_comb
    for (int i = 0; i < NP; i++) fill_level[i*FW +: FW] = FW'(fill_m[i]);

  pkt_avail_status uut (
    .clk(clk), .rst_n(rst_n), .thr_wr_en(thr_wr_en), .thr_wr_data(thr_wr_data),
    .fill_level(fill_level), .eop_push(eop_push), .eop_pop(eop_pop),
    .poll_addr(poll_addr), .direct_avail(direct_avail),
    .poll_avail(poll_avail), .poll_oe(poll_oe));

  function automatic logic model_avail(int p);
    return (cnt_m[p] != 0) || (thr_m == 0) || (fill_m[p] >= thr_m);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drive at negedge, check direct flags 1ns later, queue the polled result, advance.
  task automatic tick(string tag);
    logic [NP-1:0] exp_dir;
    logic hit, av;
    #1;
    for (int i = 0; i < NP; i++) exp_dir[i] = model_avail(i);
    check({tag, " direct"}, 32'(direct_avail), 32'(exp_dir));
    hit = 0; av = 0;
    for (int i = 0; i < NP; i++)
      if (poll_addr == 5'(i) && poll_addr != 5'h1F) begin hit = 1; av = exp_dir[i]; end
    expq.push_back({av, hit});
    tagq.push_back(tag);
    for (int i = 0; i < NP; i++) begin
      if (eop_push[i] && !eop_pop[i] && cnt_m[i] < 63) cnt_m[i]++;
      else if (eop_pop[i] && !eop_push[i] && cnt_m[i] > 0) cnt_m[i]--;
    end
    if (thr_wr_en) thr_m = int'(thr_wr_data);
    @(negedge clk);
    eop_push = '0; eop_pop = '0; thr_wr_en = 1'b0;
  endtask

  // Monitor: polled outputs are due one rising edge after their stimulus.
  initial forever begin
    @(posedge clk);
    #2;
    if (expq.size() > 0) begin
      logic [1:0] e;
      string t;
      e = expq.pop_front();
      t = tagq.pop_front();
      check({t, " poll_oe R6"}, 32'(poll_oe), 32'(e[0]));
      check({t, " poll_avail R6"}, 32'(poll_avail), 32'(e[1]));
    end
  end

  initial begin
    #3000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NP; i++) begin fill_m[i] = 0; cnt_m[i] = 0; end
    thr_m = 32;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check("R10 reset direct", 32'(direct_avail), 32'h0);
    check("R10 reset poll_oe", 32'(poll_oe), 32'h0);
    check("R10 reset poll_avail", 32'(poll_avail), 32'h0);
    @(negedge clk);

    // R2/R3: default threshold 32
    poll_addr = 5'd0; fill_m[0] = 31; tick("R3 fill31");
    fill_m[0] = 32; tick("R2 fill32");
    fill_m[0] = 33; fill_m[2] = 31; tick("R2 mixed");
    fill_m[0] = 0; fill_m[2] = 0; tick("R2 clear");

    // R1/R5 counting on port 1
    poll_addr = 5'd1; eop_push[1] = 1; tick("R5 push");
    tick("R1 held");
    eop_push[1] = 1; eop_pop[1] = 1; tick("R5 both");
    eop_pop[1] = 1; tick("R5 pop");
    tick("R5 empty");
    eop_pop[1] = 1; tick("R5 pop at zero");
    tick("R5 stay zero");
    eop_push[1] = 1; tick("R5 push2");
    eop_push[1] = 1; tick("R5 push3");
    eop_pop[1] = 1; tick("R5 pop2");
    tick("R1 one left");
    eop_pop[1] = 1; tick("R5 pop3");

    // R3 threshold write
    thr_wr_en = 1; thr_wr_data = 12'd100; fill_m[3] = 50; poll_addr = 5'd3; tick("R3 write");
    tick("R3 fill50");
    fill_m[3] = 100; tick("R3 fill100");
    fill_m[3] = 99; tick("R3 fill99");

    // R4 zero threshold
    thr_wr_en = 1; thr_wr_data = '0; tick("R4 write0");
    tick("R4 all high");
    thr_wr_en = 1; thr_wr_data = 12'd32; tick("R3 restore");
    fill_m[3] = 0; tick("R3 restored");

    // R7/R8 address decode
    poll_addr = 5'h1F; fill_m[2] = 40; tick("R7 null addr");
    poll_addr = 5'd7; tick("R7 foreign addr");
    poll_addr = 5'd4; tick("R8 just past range");
    poll_addr = 5'd2; tick("R8 port2");
    poll_addr = 5'd0; tick("R8 port0");

    // R9 polling one port while another changes
    poll_addr = 5'd3; eop_push[0] = 1; tick("R9 push p0 poll p3");
    poll_addr = 5'd0; tick("R9 poll p0");
    poll_addr = 5'd1; eop_pop[0] = 1; fill_m[1] = 32; tick("R9 pop p0 poll p1");
    poll_addr = 5'h1F; tick("R9 idle");
    tick("R9 drain");
    @(negedge clk);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule